// File: doc/BRIEF.md
# FDL Transmit Zero-Bit Inserter

This block sends facility data link bytes into an outgoing T1 stream one bit at a time. A host pushes bytes into a one-entry holding register through a valid/ready handshake. The framer pulses a slot strobe for every data link bit position in the line. On each strobe the block produces exactly one bit, and that bit is presented one clock later. Bytes leave least significant bit first.

With bit stuffing switched on, the block watches the bits it has actually sent. Once five ones in a row have gone out, it spends the next slot on a forced 0. The data shifter holds still during that slot, so no payload bit is lost. As a result the line never carries the flag pattern (a 0, six 1s, a 0) or the abort pattern (eight 1s) by accident. The count of consecutive ones carries over from one byte to the next. Any transmitted 0 clears it, and that includes a stuffed 0.

With stuffing switched off, payload bits pass through unchanged and the count stays at zero. A single-cycle pulse marks the slot in which the last data bit of a byte goes out. If the host has not refilled the holding register by the time the next byte is fetched, the block sends the previous byte again.

Top module: `fdl_zero_inserter`

## Requirements
- R1: While reset is asserted, tx_vld, byte_req and tx_bit are 0 and s_ready is 1. The repeat byte after reset is 0x00.
- R2: Every cycle with bit_req high produces tx_vld high in the following cycle, carrying that slot's bit on tx_bit. A cycle without bit_req is followed by tx_vld low.
- R3: Data bits of a byte leave in order from bit 0 (LSB) to bit 7. There are exactly 8 data slots per byte.
- R4: With ins_en high, if the five most recently sent bits were all 1, the next slot sends a 0. That slot consumes no data bit: the pending data bit is sent in the slot after it.
- R5: The consecutive-ones count carries across byte boundaries. Any sent 0, data or stuffed, sets it back to zero.
- R6: With ins_en low, every slot sends a data bit and nothing is stuffed. The count is held at zero, so after ins_en rises, stuffing starts only after five new consecutive 1s.
- R7: byte_req pulses for one cycle, aligned with the tx_vld cycle of the last data bit (bit 7) of a byte.
- R8: s_ready is high exactly when the holding register is empty. A byte is accepted on a cycle with s_valid and s_ready both high. The register empties when the first data bit of a byte is sent. While s_ready is low, s_valid is back-pressured and s_data is not taken.
- R9: If the holding register is empty when a byte's first data slot comes, the byte last accepted is sent again.
- R10: While ins_en stays high, tx_bit never shows more than five consecutive 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Zero-bit stuffing enable |
| bit_req | input | 1 | Data link bit slot strobe from the framer |
| s_valid | input | 1 | Host byte valid |
| s_ready | output | 1 | Holding register empty, byte can be accepted |
| s_data | input | 8 | Host byte |
| tx_bit | output | 1 | Bit for the current slot |
| tx_vld | output | 1 | tx_bit is valid (one cycle after bit_req) |
| byte_req | output | 1 | Last data bit of a byte is being sent |

## Verification
Each slot result (tx_vld, tx_bit, and byte_req on a byte's final bit) is due exactly one clock after the bit_req cycle that caused it. s_ready changes on the same edge that accepts or fetches a byte. A behavioural model in the bench updates on each rising edge from the inputs it sampled there, using a byte queue for the holding register and integer counters for the bit position and the ones run. The outputs are compared with it on the following falling edge, so every check falls in the cycle where the registered result first appears. The bench applies dense, sparse and starved strobe patterns, runs with stuffing on and off, and toggles the enable in the middle of a run of ones.

// File: rtl/fdl_zi_pkg.sv
package fdl_zi_pkg;
  localparam int unsigned FDL_BYTE_W  = 8;
  localparam int unsigned FDL_RUN_MAX = 5;
endpackage

// File: rtl/fdl_zi_hold.sv
module fdl_zi_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q
);
  logic full_q;

  assign s_ready = !full_q;

  // A fetch reads the old contents; a write in the same cycle refills.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (take)
        full_q <= 1'b0;
      if (s_valid && !full_q) begin
        full_q <= 1'b1;
        hold_q <= s_data;
      end
    end
  end
endmodule

// File: rtl/fdl_zi_serial.sv
module fdl_zi_serial #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [DATA_W-1:0] hold_q,
  output logic              data_bit,
  output logic              at_first,
  output logic              at_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] src;
  logic [IDX_W-1:0]  idx_q;

  assign at_first = (idx_q == '0);
  assign at_last  = (idx_q == LAST_IDX);
  // First slot of a byte reads straight from the holding register.
  assign src      = at_first ? hold_q : cur_q;
  assign data_bit = src[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      idx_q <= '0;
    end else if (adv) begin
      if (at_first)
        cur_q <= hold_q;
      idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/fdl_zi_runctr.sv
module fdl_zi_runctr #(
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_en,
  input  logic slot,
  input  logic sent_bit,
  output logic stuff_now
);
  generate
    if (RUN_LEN > 0) begin : g_count
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
      logic [CNT_W-1:0] cnt_q;

      assign stuff_now = ins_en && (cnt_q == LIMIT);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (!ins_en)
          cnt_q <= '0;
        else if (slot)
          cnt_q <= sent_bit ? cnt_q + CNT_W'(1) : '0;
      end
    end else begin : g_none
      assign stuff_now = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fdl_zero_inserter.sv
module fdl_zero_inserter
  import fdl_zi_pkg::*;
#(
  parameter int unsigned DATA_W  = FDL_BYTE_W,
  parameter int unsigned RUN_LEN = FDL_RUN_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic              bit_req,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              tx_bit,
  output logic              tx_vld,
  output logic              byte_req
);
  logic [DATA_W-1:0] hold_q;
  logic stuff_now, slot_adv, data_bit, sent_bit, at_first, at_last, take;

  assign slot_adv = bit_req && !stuff_now;
  assign sent_bit = stuff_now ? 1'b0 : data_bit;
  assign take     = slot_adv && at_first;

  fdl_zi_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .take(take), .hold_q(hold_q)
  );

  fdl_zi_serial #(.DATA_W(DATA_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .hold_q(hold_q),
    .data_bit(data_bit), .at_first(at_first), .at_last(at_last)
  );

  fdl_zi_runctr #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .slot(bit_req),
    .sent_bit(sent_bit), .stuff_now(stuff_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit   <= 1'b0;
      tx_vld   <= 1'b0;
      byte_req <= 1'b0;
    end else begin
      tx_vld   <= bit_req;
      byte_req <= slot_adv && at_last;
      if (bit_req)
        tx_bit <= sent_bit;
    end
  end
endmodule

// File: rtl/fdl_zero_inserter_chk.sv
module fdl_zero_inserter_chk #(
  parameter int unsigned RUN_LEN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic ins_en,
  input logic bit_req,
  input logic s_ready,
  input logic tx_bit,
  input logic tx_vld,
  input logic byte_req
);
  logic       en_d;
  logic [7:0] ck_q, ck_now;

  // Ones seen on the line, counted only for bits emitted with stuffing on.
  always_comb begin
    if (!en_d)                 ck_now = '0;
    else if (tx_vld && tx_bit) ck_now = ck_q + 8'd1;
    else if (tx_vld)           ck_now = '0;
    else                       ck_now = ck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      ck_q <= '0;
    end else begin
      en_d <= ins_en;
      ck_q <= ck_now;
    end
  end

  a_r2_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(bit_req));
  a_r2_no_req_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_req |=> !tx_vld);
  a_r4_zero_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && bit_req && ck_now == 8'(RUN_LEN)) |=> (tx_vld && !tx_bit));
  a_r7_breq_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> tx_vld);
  a_r7_breq_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);
  a_r8_ready_reopens_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(bit_req));
  a_r10_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ck_now <= 8'(RUN_LEN));
endmodule

bind fdl_zero_inserter fdl_zero_inserter_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .bit_req(bit_req),
  .s_ready(s_ready), .tx_bit(tx_bit), .tx_vld(tx_vld), .byte_req(byte_req)
);

// File: tb/fdl_zero_inserter_bench.sv
`timescale 1ns/1ps
module fdl_zero_inserter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_en = 1'b0, bit_req = 1'b0, s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, tx_bit, tx_vld, byte_req;

  always #2.5 clk = ~clk;

  fdl_zero_inserter u_fdl_zero_inserter (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .bit_req(bit_req),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tx_bit(tx_bit), .tx_vld(tx_vld), .byte_req(byte_req)
  );

  int checks = 0, errors = 0;
  string ph = "R3";
  int mode = 0, tick = 0;
  bit track = 0, started = 0;
  int run = 0;

  // reference model state
  int q[$];
  int last_b = 0, cur_b = 0, bpos = 0, ones = 0;
  bit e_vld = 0, e_bit = 0, e_breq = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // strobe generator: 0 off, 1 every cycle, 2 every third cycle
  always @(negedge clk) begin
    tick++;
    bit_req <= (mode == 1) || (mode == 2 && (tick % 3) == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); last_b = 0; cur_b = 0; bpos = 0; ones = 0;
      e_vld = 0; e_bit = 0; e_breq = 0;
    end else begin
      bit wr;
      wr = s_valid && (q.size() == 0);
      e_vld = bit_req; e_breq = 0;
      if (bit_req) begin
        if (ins_en && ones == 5) begin
          e_bit = 0; ones = 0;
        end else begin
          if (bpos == 0) begin
            if (q.size() > 0) last_b = q.pop_front();
            cur_b = last_b;
          end
          e_bit = (cur_b >> bpos) & 1;
          ones = (ins_en && e_bit) ? ones + 1 : 0;
          bpos++;
          if (bpos == 8) begin bpos = 0; e_breq = 1; end
        end
      end
      if (!ins_en) ones = 0;
      if (wr) q.push_back(s_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      chk({ph, " R2 tx_vld"}, tx_vld, e_vld);
      if (e_vld) chk({ph, " tx_bit"}, tx_bit, e_bit);
      chk("R7 byte_req", byte_req, e_breq);
      chk("R8 s_ready", s_ready, q.size() == 0);
      if (!track) run = 0;
      else if (tx_vld) begin
        run = tx_bit ? run + 1 : 0;
        if (run > 5) chk("R10 ones run", run, 5);
      end
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    s_data = b; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 tx_vld", tx_vld, 0);
    chk("R1 byte_req", byte_req, 0);
    chk("R1 tx_bit", tx_bit, 0);
    chk("R1 s_ready", s_ready, 1);
    rst_n = 1'b1; started = 1;
    idle(2);
    // R9 right after reset: nothing loaded, zeros repeat
    ph = "R9"; mode = 1; idle(12); mode = 0; idle(12);
    // R3 and R6: stuffing off, ones pass through
    ph = "R6"; ins_en = 1'b0;
    push(8'hA5); mode = 1; push(8'hFF); push(8'hFF); push(8'h3C); idle(40);
    mode = 0; idle(12);
    // R4 and R5: stuffing on, runs inside and across bytes
    ph = "R4"; ins_en = 1'b1; idle(2); track = 1;
    push(8'hFF); mode = 1; push(8'hFF); push(8'h1F); push(8'hF8);
    ph = "R5"; push(8'hF0); push(8'h0F); push(8'h7E); push(8'hBE);
    idle(60);
    // R9: starve the holding register, last byte repeats
    ph = "R9"; push(8'hFB); idle(50);
    // R8: sparse slots, host pushes back to back under back-pressure
    ph = "R8"; mode = 2;
    push(8'h81); push(8'hFF); push(8'h55); push(8'hFE);
    idle(120);
    // R6: drop and raise the enable in the middle of a ones run
    ph = "R6"; track = 0; mode = 1;
    push(8'hFF); push(8'hFF); push(8'hFF);
    idle(3); ins_en = 1'b0; idle(4); ins_en = 1'b1; idle(9);
    ins_en = 1'b0; idle(2); ins_en = 1'b1;
    idle(40);
    mode = 0; idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule